// File: doc/BRIEF.md
# Ethernet Transmit Frame Encapsulator

This block turns the payload of one frame, handed over byte by byte from a transmit buffer, into a complete nibble-wide transmit stream for a media-independent PHY interface. The buffer offers each byte with a valid flag and marks the final byte of the frame. The block puts the preamble and start delimiter in front of the payload. It then adds zero bytes when the frame is too short and closes the frame with a 32-bit frame check sequence. Between frames it holds the line idle for a fixed gap.

Two control bits are sampled when a frame starts and apply to that whole frame. One suppresses padding and the other suppresses the check sequence. The source may change them freely once the frame has begun. The source must keep a byte ready whenever the block requests one inside a frame. The clock runs at nibble rate, so one nibble leaves on each cycle.

Top module: `eth_tx_encap`

## Requirements
- R1: While reset is high and on the cycle after it, `tx_en` and `in_ready` are 0. `txd` reads 0 whenever `tx_en` is 0.
- R2: A frame opens with 15 nibbles of value 4'h5. `txd[0]` is the bit sent first, and every byte goes out low nibble first.
- R3: The 16th nibble is 4'hD, which completes a start delimiter byte of 8'hD5.
- R4: Payload bytes follow in the order they were accepted, low nibble then high nibble. `tx_en` stays high without a break from the first preamble nibble to the last nibble of the frame. `in_ready` is high only while `tx_en` is high.
- R5: With the check sequence enabled and padding allowed, a payload shorter than 60 bytes is followed by 8'h00 bytes until payload plus pad is 60 bytes.
- R6: With the check sequence inhibited and padding allowed, zero padding brings the frame to 64 bytes.
- R7: With `pad_dis` high, no pad byte is sent, whatever the payload length.
- R8: With `crc_inh` low, 8 nibbles of check sequence follow the payload and pad. The CRC uses generator 32'h04C11DB7, is preset to all ones, covers payload and pad bytes only, and is complemented at the end. The first check nibble carries the x^31 coefficient on `txd[0]` down to x^28 on `txd[3]`, and so on to x^0 on `txd[3]` of the last nibble.
- R9: With `crc_inh` high, the frame ends right after the last payload or pad nibble.
- R10: After a frame, `tx_en` stays low for at least 24 cycles and `in_ready` stays low throughout. If the next frame's first byte is already valid, the gap is exactly 24 cycles.
- R11: `pad_dis` and `crc_inh` are sampled when a frame starts. Changes to them during that frame have no effect on it.
- R12: Exactly one handshake takes place per payload byte, and `in_ready` is never high on two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Payload byte from the buffer |
| in_valid | input | 1 | Payload byte is valid; when idle, requests a new frame |
| in_last | input | 1 | Marks the final payload byte |
| pad_dis | input | 1 | Suppress padding for the starting frame |
| crc_inh | input | 1 | Suppress the check sequence for the starting frame |
| in_ready | output | 1 | Byte is taken at this clock edge when valid |
| txd | output | 4 | Transmit nibble, bit 0 sent first |
| tx_en | output | 1 | Transmit enable |

## Verification
`tx_en` rises one cycle after the edge at which a valid first byte is seen in the idle state, or at the end of the gap. Every later nibble then follows from the frame length and the two sampled control bits. The bench therefore predicts the whole nibble sequence of each frame, including a check sequence it computes with a reflected, byte-wise CRC, and compares it with what it records while `tx_en` is high. It samples on falling edges only, and so compares frame content and length rather than absolute cycle numbers. Gap length, ready spacing and the handshake count per frame are counted on the same falling edges. Payload lengths around the 60- and 64-byte limits are swept across all four control combinations, back to back. The control inputs are inverted once each frame has started.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DATA,
        S_PAD,
        S_CRC,
        S_IFG
    } tx_state_t;

    localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [3:0]  NIB_PRE    = 4'h5;
    localparam logic [3:0]  NIB_SFD_HI = 4'hD;
    localparam int          FCS_BYTES  = 4;
    localparam int          FCS_NIBS   = 2 * FCS_BYTES;

    // Advance the CRC by one nibble, bit 0 first (serial wire order).
    function automatic logic [31:0] crc_nib_step(input logic [31:0] c, input logic [3:0] nib);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 4; i++) begin
            if (r[31] ^ nib[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
            else                r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

    // Complemented top four coefficients, x^31 placed on bit 0.
    function automatic logic [3:0] fcs_out(input logic [31:0] c);
        return ~{c[28], c[29], c[30], c[31]};
    endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init,
    input  logic       update,
    input  logic       shift,
    input  logic [3:0] nib_in,
    output logic [3:0] fcs_nib
);
    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init)  crc_q <= '1;
        else if (update)  crc_q <= crc_nib_step(crc_q, nib_in);
        else if (shift)   crc_q <= {crc_q[27:0], 4'h0};
    end

    assign fcs_nib = fcs_out(crc_q);

    a_r8_preset_after_init: assert property (@(posedge clk) disable iff (rst)
        init |=> (fcs_nib == 4'h0));
endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
    import eth_tx_pkg::*;
#(
    parameter int MIN_FRAME = 64,
    parameter int IFG_CYC   = 24,
    parameter int PRE_NIBS  = 16,
    localparam int CW = $clog2(IFG_CYC + PRE_NIBS + FCS_NIBS),
    localparam int BW = $clog2(MIN_FRAME + 1) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    in_data,
    input  logic          in_valid,
    input  logic          in_last,
    input  logic          pad_dis,
    input  logic          crc_inh,
    output logic          in_ready,
    output tx_state_t     st,
    output logic [CW-1:0] cnt,
    output logic          ph,
    output logic [7:0]    byte_q
);
    logic          last_q, pd_q, ci_q;
    logic [BW-1:0] bcnt, target, bnext;
    tx_state_t     after_data;

    assign target   = ci_q ? BW'(MIN_FRAME) : BW'(MIN_FRAME - FCS_BYTES);
    assign bnext    = (bcnt == '1) ? bcnt : bcnt + 1'b1;
    assign in_ready = (st == S_PRE  && cnt == CW'(PRE_NIBS - 1)) ||
                      (st == S_DATA && ph && !last_q);
    assign after_data = (!pd_q && bcnt < target) ? S_PAD : (ci_q ? S_IFG : S_CRC);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            ph     <= 1'b0;
            byte_q <= '0;
            last_q <= 1'b0;
            pd_q   <= 1'b0;
            ci_q   <= 1'b0;
            bcnt   <= '0;
        end else begin
            case (st)
                S_IDLE: if (in_valid) begin
                    st   <= S_PRE;
                    cnt  <= '0;
                    pd_q <= pad_dis;
                    ci_q <= crc_inh;
                end
                S_PRE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(PRE_NIBS - 1)) begin
                        st     <= S_DATA;
                        cnt    <= '0;
                        ph     <= 1'b0;
                        bcnt   <= BW'(1);
                        byte_q <= in_data;
                        last_q <= in_last;
                    end
                end
                S_DATA: begin
                    ph <= ~ph;
                    if (ph) begin
                        if (last_q) begin
                            st <= after_data;
                            ph <= 1'b0;
                        end else begin
                            byte_q <= in_data;
                            last_q <= in_last;
                            bcnt   <= bnext;
                        end
                    end
                end
                S_PAD: begin
                    ph <= ~ph;
                    if (ph) begin
                        bcnt <= bnext;
                        if (bnext >= target) begin
                            st <= ci_q ? S_IFG : S_CRC;
                            ph <= 1'b0;
                        end
                    end
                end
                S_CRC: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(FCS_NIBS - 1)) begin
                        st  <= S_IFG;
                        cnt <= '0;
                    end
                end
                default: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(IFG_CYC - 1)) begin
                        cnt <= '0;
                        if (in_valid) begin
                            st   <= S_PRE;
                            pd_q <= pad_dis;
                            ci_q <= crc_inh;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    a_r6_pad_below_target: assert property (@(posedge clk) disable iff (rst)
        (st == S_PAD) |-> (bcnt < target));
    a_r7_no_pad_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (st == S_PAD) |-> !pd_q);
    a_r12_ready_spacing: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);
endmodule

// File: rtl/eth_tx_encap.sv
module eth_tx_encap
    import eth_tx_pkg::*;
#(
    parameter int MIN_FRAME = 64,
    parameter int IFG_CYC   = 24,
    parameter int PRE_NIBS  = 16,
    localparam int CW = $clog2(IFG_CYC + PRE_NIBS + FCS_NIBS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       pad_dis,
    input  logic       crc_inh,
    output logic       in_ready,
    output logic [3:0] txd,
    output logic       tx_en
);
    tx_state_t     st;
    logic [CW-1:0] cnt;
    logic          ph;
    logic [7:0]    byte_q;
    logic [3:0]    fcs_nib, body_nib;

    eth_tx_seq #(.MIN_FRAME(MIN_FRAME), .IFG_CYC(IFG_CYC), .PRE_NIBS(PRE_NIBS)) u_seq (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .pad_dis(pad_dis), .crc_inh(crc_inh), .in_ready(in_ready),
        .st(st), .cnt(cnt), .ph(ph), .byte_q(byte_q)
    );

    assign body_nib = (st == S_DATA) ? (ph ? byte_q[7:4] : byte_q[3:0]) : 4'h0;

    eth_tx_crc u_crc (
        .clk(clk), .rst(rst),
        .init(st == S_PRE),
        .update(st == S_DATA || st == S_PAD),
        .shift(st == S_CRC),
        .nib_in(body_nib),
        .fcs_nib(fcs_nib)
    );

    always_comb begin
        unique case (st)
            S_PRE:   txd = (cnt == CW'(PRE_NIBS - 1)) ? NIB_SFD_HI : NIB_PRE;
            S_DATA:  txd = body_nib;
            S_CRC:   txd = fcs_nib;
            default: txd = 4'h0;
        endcase
    end

    assign tx_en = (st == S_PRE) || (st == S_DATA) || (st == S_PAD) || (st == S_CRC);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!tx_en && !in_ready));
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !tx_en |-> (txd == 4'h0));
    a_r4_ready_inside_frame: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> tx_en);
    a_r10_gap_follows_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_en) |=> !tx_en);
endmodule

// File: tb/sim_eth_tx_encap.sv
module sim_eth_tx_encap;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] in_data;
    logic       in_valid, in_last, pad_dis, crc_inh;
    logic       in_ready, tx_en;
    logic [3:0] txd;

    always #5 clk = ~clk;

    eth_tx_encap u0 (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
        .pad_dis(pad_dis), .crc_inh(crc_inh), .in_ready(in_ready), .txd(txd), .tx_en(tx_en)
    );

    int n_chk = 0;
    int n_bad = 0;

    // frame descriptors, recorded by the driver, consumed by the monitor
    int fr_len [64];
    bit fr_pd  [64];
    bit fr_ci  [64];
    int n_sent = 0;
    int n_seen = 0;

    logic [3:0] rec [256];
    int         rn = 0;
    int         hs = 0;
    int         gap = 0;
    bit         prev_en = 1'b0;

    logic [3:0] exp_n [256];
    string      exp_t [256];
    int         exp_len;
    string      len_tag;

    function automatic logic [7:0] pay(input int k, input int i);
        return 8'((k * 37 + i * 13 + 5) & 255);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [3:0] v, input string t);
        exp_n[exp_len] = v;
        exp_t[exp_len] = t;
        exp_len++;
    endtask

    task automatic build(input int k);
        logic [7:0]  body [80];
        int          nb, tgt;
        logic [31:0] c;
        exp_len = 0;
        for (int i = 0; i < 15; i++) push(4'h5, "R2");
        push(4'hD, "R3");
        nb = fr_len[k];
        for (int i = 0; i < nb; i++) body[i] = pay(k, i);
        for (int i = 0; i < nb; i++) begin
            push(body[i][3:0], "R4");
            push(body[i][7:4], "R4");
        end
        tgt = fr_ci[k] ? 64 : 60;
        if (!fr_pd[k]) begin
            while (nb < tgt) begin
                body[nb] = 8'h00;
                push(4'h0, fr_ci[k] ? "R6" : "R5");
                push(4'h0, fr_ci[k] ? "R6" : "R5");
                nb++;
            end
        end
        if (!fr_ci[k]) begin
            c = 32'hFFFFFFFF;
            for (int i = 0; i < nb; i++) begin
                c = c ^ {24'h0, body[i]};
                for (int b = 0; b < 8; b++)
                    c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
            end
            c = ~c;
            for (int i = 0; i < 8; i++) push(c[4*i +: 4], "R8");
        end
        if (fr_ci[k])      len_tag = "R9 R11";
        else if (fr_pd[k]) len_tag = "R7 R11";
        else               len_tag = "R5 R11";
    endtask

    task automatic finish_frame();
        if (n_seen >= n_sent) begin
            check(1'b0, "R4 unexpected frame", n_seen, n_sent);
            return;
        end
        build(n_seen);
        check(rn == exp_len, len_tag, rn, exp_len);
        for (int i = 0; i < rn && i < exp_len; i++)
            check(rec[i] == exp_n[i], exp_t[i], int'(rec[i]), int'(exp_n[i]));
        check(hs == fr_len[n_seen], "R12 handshakes", hs, fr_len[n_seen]);
        n_seen++;
    endtask

    // monitor: all sampling on falling edges
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_en) begin
                if (!prev_en) begin
                    if (n_seen > 0) check(gap == 24, "R10 gap", gap, 24);
                    rn = 0;
                    hs = 0;
                end
                if (rn < 256) rec[rn] = txd;
                rn++;
                if (in_ready && in_valid) hs++;
            end else begin
                if (prev_en) begin
                    finish_frame();
                    gap = 0;
                end
                gap++;
                if (in_ready) check(1'b0, "R10 ready in gap", 1, 0);
                if (txd != 4'h0) check(1'b0, "R1 idle txd", int'(txd), 0);
            end
            prev_en = tx_en;
        end
    end

    task automatic send(input int len, input bit pd, input bit ci);
        fr_len[n_sent] = len;
        fr_pd[n_sent]  = pd;
        fr_ci[n_sent]  = ci;
        pad_dis = pd;
        crc_inh = ci;
        for (int i = 0; i < len; i++) begin
            in_data  = pay(n_sent, i);
            in_last  = (i == len - 1);
            in_valid = 1'b1;
            do @(negedge clk); while (!in_ready);
            // R11: controls flip after the frame has started
            pad_dis = ~pd;
            crc_inh = ~ci;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        n_sent++;
    endtask

    initial begin
        int lens [10] = '{1, 2, 30, 59, 60, 61, 63, 64, 65, 70};
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0;
        in_data = 8'h00; pad_dis = 1'b0; crc_inh = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(tx_en == 1'b0, "R1 tx_en in reset", int'(tx_en), 0);
        check(in_ready == 1'b0, "R1 ready in reset", int'(in_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        check(tx_en == 1'b0, "R1 tx_en after reset", int'(tx_en), 0);
        check(txd == 4'h0, "R1 txd after reset", int'(txd), 0);
        check(in_ready == 1'b0, "R1 ready after reset", int'(in_ready), 0);
        for (int c = 0; c < 4; c++)
            for (int li = 0; li < 10; li++)
                send(lens[li], c[0], c[1]);
        while (n_seen < n_sent) @(negedge clk);
        repeat (30) @(negedge clk);
        check(n_seen == n_sent, "R4 frame count", n_seen, n_sent);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R4 watchdog expired actual=%0d expected=%0d", n_seen, n_sent);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule